// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects an internal bus master to an external asynchronous static RAM that holds 32,768 words of 16 bits. The master presents an address, a direction flag, two byte-enable bits and write data with a valid/ready handshake. For each accepted request the controller drives the memory's active-low select, write, output-enable and per-byte strobe pins over a fixed number of clock cycles. The cycle count is set by parameters so that it covers the memory's access and cycle times.

A write holds the write strobe low for a set number of cycles. It then raises the write strobe while chip select, address and data stay unchanged, because the memory captures data on that rising edge. A read holds output enable low and samples the data bus on the last strobe cycle. The read data comes back on a one-cycle response pulse, and byte lanes that were not requested read as zero. When a write follows a read, the controller inserts idle turnaround cycles, so it never drives the shared data bus while the memory may still be driving it. Between accesses the memory is kept deselected, which is its standby state. A request with no byte enabled finishes at once without selecting the memory.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, the select, write, output-enable and both byte strobes are high (inactive), the data drive enable is low and `req_ready` is high.
- R2: A write with a nonzero byte mask holds select low, write low, output enable high and the drive enable high for STROBE_CYC cycles (default 2). During those cycles the address and the driven data equal the request, and each byte strobe is low exactly where its mask bit is set.
- R3: In the cycle after the last write-strobe cycle, the write pin goes high while select stays low and the address, data and drive enable stay unchanged. In the cycle after that the memory is deselected and `req_ready` is high again.
- R4: A read with a nonzero byte mask holds select low, output enable low, write high and the drive enable low for STROBE_CYC cycles, with the byte strobes equal to the inverted mask.
- R5: `rsp_valid` is high for exactly the one cycle after the last read-strobe cycle. Its data holds, for each enabled lane, the bus value sampled on that last strobe cycle, and zero for each disabled lane.
- R6: The drive enable is never high while output enable is low.
- R7: A write accepted after a read (with no write in between) is preceded by TURN_CYC cycles (default 1) in which select is high, the drive enable is low and `req_ready` is low.
- R8: A request with byte mask 00 never lowers select and leaves `req_ready` high. If it is a read, `rsp_valid` pulses in the next cycle with all-zero data.
- R9: `req_ready` is low while an access is in progress. A `req_valid` raised while `req_ready` is low is ignored and causes no later memory access.
- R10: Mask bit 0 and strobe bit 0 govern data bits 7:0. Mask bit 1 and strobe bit 1 govern data bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_be | input | 2 | Byte mask, bit 0 = low byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read response |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lane_n | output | 2 | Byte strobes, bit 0 = low byte, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Data drive enable |
| mem_dq_in | input | 16 | Data received from memory |

## Verification
If the sequencing state goes wrong, the pins show it within a single cycle. A strobe can stay low too long or drop too early, the write pin can rise after select has already gone high, or the drive enable can overlap output enable; the memory model reports the last of these as bus contention in the same cycle. If the lane logic or the captured request goes wrong, the wrong value shows up on the next read-back of that address, so the random traffic is kept to a narrow address window. A missing turnaround shows as a write strobe in the cycle right after a read's response.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_TURN = 3'd1,
      ST_WSTB = 3'd2,
      ST_WHLD = 3'd3,
      ST_RSTB = 3'd4
   } seq_state_t;

   function automatic int cnt_width(input int a, input int b);
      int m;
      m = (a > b) ? a : b;
      return (m < 2) ? 1 : $clog2(m);
   endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_lane_pkg::*;
#(
   parameter int STROBE_CYC = 2,
   parameter int TURN_CYC   = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       req_we,
   input  logic       mask_zero,
   output logic       accept,
   output logic       capture,
   output logic       zero_read,
   output seq_state_t state
);

   localparam int CNT_W = cnt_width(STROBE_CYC, TURN_CYC);
   localparam logic [CNT_W-1:0] STB_LAST  = CNT_W'(STROBE_CYC - 1);
   localparam logic [CNT_W-1:0] TURN_LAST = (TURN_CYC > 0) ? CNT_W'(TURN_CYC - 1) : '0;

   seq_state_t       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             last_rd_q;
   logic             turn_need;

   generate
      if (TURN_CYC > 0) begin : g_turn
         assign turn_need = last_rd_q;
      end else begin : g_noturn
         assign turn_need = 1'b0;
      end
   endgenerate

   assign state     = state_q;
   assign accept    = req_valid && (state_q == ST_IDLE);
   assign capture   = (state_q == ST_RSTB) && (cnt_q == STB_LAST);
   assign zero_read = accept && mask_zero && !req_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         last_rd_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               cnt_q <= '0;
               if (accept && !mask_zero) begin
                  if (!req_we)        state_q <= ST_RSTB;
                  else if (turn_need) state_q <= ST_TURN;
                  else                state_q <= ST_WSTB;
               end
            end
            ST_TURN: begin
               if (cnt_q == TURN_LAST) begin
                  cnt_q   <= '0;
                  state_q <= ST_WSTB;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_WSTB: begin
               last_rd_q <= 1'b0;
               if (cnt_q == STB_LAST) begin
                  cnt_q   <= '0;
                  state_q <= ST_WHLD;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_WHLD: state_q <= ST_IDLE;
            ST_RSTB: begin
               if (cnt_q == STB_LAST) begin
                  cnt_q     <= '0;
                  last_rd_q <= 1'b1;
                  state_q   <= ST_IDLE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sram_lane_path.sv
module sram_lane_path #(
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              mask_in,
   input  logic [LANE_W-1:0] wdata_in,
   input  logic              strobe_on,
   input  logic              capture,
   input  logic              clear,
   input  logic [LANE_W-1:0] dq_in,
   output logic              lane_n,
   output logic [LANE_W-1:0] dq_out,
   output logic [LANE_W-1:0] rdata
);

   logic              mask_q;
   logic [LANE_W-1:0] wdata_q;
   logic [LANE_W-1:0] rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= 1'b0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         if (load) begin
            mask_q  <= mask_in;
            wdata_q <= wdata_in;
         end
         if (clear)        rdata_q <= '0;
         else if (capture) rdata_q <= mask_q ? dq_in : '0;
      end
   end

   assign lane_n = !(strobe_on && mask_q);
   assign dq_out = wdata_q;
   assign rdata  = rdata_q;

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_lane_pkg::*;
#(
   parameter int ADDR_W     = 15,
   parameter int LANES      = 2,
   parameter int LANE_W     = 8,
   parameter int STROBE_CYC = 2,
   parameter int TURN_CYC   = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic                     req_we,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [LANES-1:0]         req_be,
   input  logic [LANES*LANE_W-1:0]  req_wdata,
   output logic                     rsp_valid,
   output logic [LANES*LANE_W-1:0]  rsp_rdata,
   output logic                     mem_ce_n,
   output logic                     mem_we_n,
   output logic                     mem_oe_n,
   output logic [LANES-1:0]         mem_lane_n,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic [LANES*LANE_W-1:0]  mem_dq_out,
   output logic                     mem_dq_oe,
   input  logic [LANES*LANE_W-1:0]  mem_dq_in
);

   generate
      if (STROBE_CYC < 1) begin : g_bad_strobe
         $error("STROBE_CYC must be at least 1");
      end
      if (TURN_CYC < 0) begin : g_bad_turn
         $error("TURN_CYC must not be negative");
      end
      if (LANES < 1 || LANE_W < 1 || ADDR_W < 1) begin : g_bad_width
         $error("widths must be positive");
      end
   endgenerate

   seq_state_t        state;
   logic              accept;
   logic              capture;
   logic              zero_read;
   logic              load;
   logic              strobe_on;
   logic              rsp_q;
   logic [ADDR_W-1:0] addr_q;

   sram_seq_fsm #(
      .STROBE_CYC(STROBE_CYC),
      .TURN_CYC  (TURN_CYC)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_we   (req_we),
      .mask_zero(req_be == '0),
      .accept   (accept),
      .capture  (capture),
      .zero_read(zero_read),
      .state    (state)
   );

   assign load      = accept && (req_be != '0);
   assign strobe_on = (state == ST_WSTB) || (state == ST_WHLD) || (state == ST_RSTB);

   genvar gl;
   generate
      for (gl = 0; gl < LANES; gl++) begin : g_lane
         sram_lane_path #(.LANE_W(LANE_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .mask_in  (req_be[gl]),
            .wdata_in (req_wdata[gl*LANE_W +: LANE_W]),
            .strobe_on(strobe_on),
            .capture  (capture),
            .clear    (zero_read),
            .dq_in    (mem_dq_in[gl*LANE_W +: LANE_W]),
            .lane_n   (mem_lane_n[gl]),
            .dq_out   (mem_dq_out[gl*LANE_W +: LANE_W]),
            .rdata    (rsp_rdata[gl*LANE_W +: LANE_W])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         rsp_q  <= 1'b0;
      end else begin
         if (load) addr_q <= req_addr;
         rsp_q <= capture || zero_read;
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign rsp_valid = rsp_q;
   assign mem_ce_n  = !strobe_on;
   assign mem_we_n  = (state != ST_WSTB);
   assign mem_oe_n  = (state != ST_RSTB);
   assign mem_dq_oe = (state == ST_WSTB) || (state == ST_WHLD);
   assign mem_addr  = addr_q;

endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk #(
   parameter int ADDR_W = 15,
   parameter int LANES  = 2,
   parameter int DW     = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              mem_ce_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [LANES-1:0]  mem_lane_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DW-1:0]     mem_dq_out,
   input logic              mem_dq_oe
);

   p_ready_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && (&mem_lane_n)));

   p_write_pins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe && !(&mem_lane_n)));

   p_we_rise_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out)
                           && $stable(mem_lane_n)));

   p_read_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (!mem_ce_n && mem_we_n && !(&mem_lane_n)));

   p_rsp_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_oe_n) && mem_we_n) |-> rsp_valid);

   p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_dq_oe);

   p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> !req_ready);

endmodule

bind sram_lane_ctrl sram_lane_chk #(
   .ADDR_W(ADDR_W),
   .LANES (LANES),
   .DW    (LANES*LANE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .mem_ce_n  (mem_ce_n),
   .mem_we_n  (mem_we_n),
   .mem_oe_n  (mem_oe_n),
   .mem_lane_n(mem_lane_n),
   .mem_addr  (mem_addr),
   .mem_dq_out(mem_dq_out),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;

   localparam int S = 2;
   localparam int T = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_we = 1'b0;
   logic [14:0] req_addr = '0;
   logic [1:0]  req_be = '0;
   logic [15:0] req_wdata = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [1:0]  mem_lane_n;
   logic [14:0] mem_addr;
   logic [15:0] mem_dq_out;
   logic [15:0] mem_dq_in = 16'hA5A5;

   int compared = 0;
   int mismatched = 0;
   bit last_rd = 1'b0;
   logic prev_we_n = 1'b1;
   logic [15:0] pin_mem [int];
   logic [15:0] ref_mem [int];

   always #2 clk = ~clk;

   sram_lane_ctrl #(.STROBE_CYC(S), .TURN_CYC(T)) i_sram_lane_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_we(req_we), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lane_n(mem_lane_n),
      .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   function automatic logic [15:0] pin_rd(input logic [14:0] a);
      return pin_mem.exists(int'(a)) ? pin_mem[int'(a)] : 16'h0000;
   endfunction

   function automatic logic [15:0] exp_rd(input logic [14:0] a, input logic [1:0] be);
      logic [15:0] w;
      w = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
      for (int l = 0; l < 2; l++) if (!be[l]) w[l*8 +: 8] = 8'h00;
      return w;
   endfunction

   // Memory model: truth-table behaviour, write on rising write strobe, contention flag
   always @(negedge clk) begin
      logic [15:0] w;
      logic        drv;
      if (rst_n && prev_we_n == 1'b0 && mem_we_n && !mem_ce_n) begin
         w = pin_rd(mem_addr);
         for (int l = 0; l < 2; l++) if (!mem_lane_n[l]) w[l*8 +: 8] = mem_dq_out[l*8 +: 8];
         pin_mem[int'(mem_addr)] = w;
      end
      prev_we_n = mem_we_n;
      drv = !mem_ce_n && mem_we_n && !mem_oe_n && !(&mem_lane_n);
      w = 16'hA5A5;
      if (drv) for (int l = 0; l < 2; l++) if (!mem_lane_n[l]) w[l*8 +: 8] = pin_rd(mem_addr) >> (l*8);
      mem_dq_in = w;
      if (rst_n && drv && mem_dq_oe) begin
         mismatched++;
         $display("FAIL R6 bus contention: act dq_oe=%0b oe_n=%0b exp no overlap", mem_dq_oe, mem_oe_n);
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic access(input bit we, input logic [14:0] a, input logic [1:0] be,
                         input logic [15:0] d, input bit poke, input string rtag);
      logic [15:0] e;
      @(negedge clk);
      chk(req_ready && mem_ce_n, "R9 idle before request", {req_ready, mem_ce_n}, 2'b11);
      req_valid = 1'b1; req_we = we; req_addr = a; req_be = be; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      if (be == 2'b00) begin
         chk(mem_ce_n && req_ready, "R8 zero mask no select", {mem_ce_n, req_ready}, 2'b11);
         if (!we) chk(rsp_valid && rsp_rdata == 16'h0, "R8 zero mask read", {rsp_valid, rsp_rdata}, {1'b1, 16'h0});
         return;
      end
      if (poke) begin
         req_valid = 1'b1; req_we = !we; req_addr = ~a; req_be = 2'b11; req_wdata = ~d;
      end
      if (we && last_rd && T > 0) begin
         for (int i = 0; i < T; i++) begin
            chk(mem_ce_n && !mem_dq_oe && !req_ready, "R7 turnaround",
                {mem_ce_n, mem_dq_oe, req_ready}, 3'b100);
            @(negedge clk);
            req_valid = 1'b0;
         end
      end
      for (int i = 0; i < S; i++) begin
         if (we)
            chk(!mem_ce_n && !mem_we_n && mem_oe_n && mem_dq_oe && mem_addr == a && mem_dq_out == d
                && mem_lane_n == ~be, "R2 R10 write strobe",
                {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, mem_lane_n, mem_addr}, {4'b0011, ~be, a});
         else
            chk(!mem_ce_n && mem_we_n && !mem_oe_n && !mem_dq_oe && mem_addr == a && mem_lane_n == ~be,
                "R4 R10 read strobe",
                {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, mem_lane_n, mem_addr}, {4'b0100, ~be, a});
         chk(!req_ready, "R9 busy", req_ready, 0);
         @(negedge clk);
         req_valid = 1'b0;
      end
      if (we) begin
         chk(!mem_ce_n && mem_we_n && mem_dq_oe && mem_addr == a && mem_dq_out == d && mem_lane_n == ~be,
             "R3 write hold", {mem_ce_n, mem_we_n, mem_dq_oe, mem_dq_out}, {3'b011, d});
         @(negedge clk);
         chk(req_ready && mem_ce_n, "R3 write done", {req_ready, mem_ce_n}, 2'b11);
         e = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
         for (int l = 0; l < 2; l++) if (be[l]) e[l*8 +: 8] = d[l*8 +: 8];
         ref_mem[int'(a)] = e;
         last_rd = 1'b0;
      end else begin
         e = exp_rd(a, be);
         chk(rsp_valid && rsp_rdata == e, rtag, {rsp_valid, rsp_rdata}, {1'b1, e});
         last_rd = 1'b1;
         @(negedge clk);
         chk(!rsp_valid && mem_ce_n, "R5 single pulse", {rsp_valid, mem_ce_n}, 2'b01);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      int seed;
      seed = 7;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && mem_lane_n == 2'b11 && !mem_dq_oe,
          "R1 reset state", {req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_oe}, 7'b1111110);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && mem_ce_n && !mem_dq_oe, "R1 idle after reset", {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);

      // Lane mapping
      access(1, 15'h0005, 2'b11, 16'h1234, 0, "R5 read");
      access(1, 15'h0005, 2'b01, 16'hABCD, 0, "R5 read");
      access(0, 15'h0005, 2'b11, 16'h0, 0, "R10 full word lane merge");
      access(0, 15'h0005, 2'b10, 16'h0, 0, "R10 upper lane only");
      access(0, 15'h0005, 2'b01, 16'h0, 0, "R10 lower lane only");
      // Read then write: turnaround
      access(1, 15'h7FFF, 2'b10, 16'hBEEF, 0, "R5 read");
      access(0, 15'h7FFF, 2'b11, 16'h0, 0, "R5 top address");
      access(1, 15'h0000, 2'b11, 16'h5AA5, 0, "R5 read");
      // Zero-mask requests
      access(0, 15'h0005, 2'b00, 16'h0, 0, "R8");
      access(1, 15'h0005, 2'b00, 16'hFFFF, 0, "R8");
      access(0, 15'h0005, 2'b11, 16'h0, 0, "R8 zero-mask write left word");
      // Ignored request while busy
      access(1, 15'h0011, 2'b11, 16'h0F0F, 1, "R9");
      access(0, 15'h0011, 2'b11, 16'h0, 1, "R9 poke did not disturb read");
      access(0, ~15'h0011, 2'b11, 16'h0, 0, "R9 poked address untouched");

      // Constrained random traffic in a narrow window
      for (int n = 0; n < 400; n++) begin
         logic [14:0] a;
         logic [1:0]  be;
         bit          we;
         a  = {11'h0, 4'($urandom)};
         be = 2'($urandom);
         we = 1'($urandom);
         access(we, a, be, 16'($urandom), ($urandom % 8) == 0, "R5 random read");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule